// File: doc/BRIEF.md
# Doubleword load/store and unsigned-word load unit

This unit sits beside a 32-bit-base integer pipeline that has been widened to 64-bit registers, and takes over the three memory operations that only exist at the wider width: the zero-extending word load, the doubleword load and the doubleword store. It receives one decoded instruction word together with both source register values. It then decides whether the instruction belongs to it and builds the sign-extended immediate. For a store, the immediate is taken from two separate fields. The unit adds the immediate to the base register and issues one request on a byte-addressed, little-endian 64-bit data port.

For loads, the returned 64-bit beat is narrowed and zero-extended if needed. The unit then presents it to the register file as a single-cycle write strobe. That strobe is suppressed when the destination is register 0. Any instruction the unit does not own is flagged back so that the base unit can execute it. Only one operation is in flight at a time. The unit drops its instruction-ready output from the moment it accepts an operation until that operation completes.

Top module: `dw_lsu`

## Requirements
- R1: An instruction with major opcode 0000011 (bits [6:0]) and funct3 110 (bits [14:12]) is a word load. It issues a read request with size code 2, and its byte enable is 0x0F when address bit 2 is 0 and 0xF0 when address bit 2 is 1.
- R2: The write-back value of a word load is the selected 32-bit half of the returned beat: bits [31:0] for address bit 2 = 0, bits [63:32] otherwise. The value is zero-extended to 64 bits, regardless of its top bit.
- R3: Opcode 0000011 with funct3 011 is a doubleword load. It issues a read with size code 3 and byte enable 0xFF, and writes the whole returned beat back unchanged.
- R4: Opcode 0100011 with funct3 011 is a doubleword store. It issues a write (req_we_o = 1) with size code 3, byte enable 0xFF and write data equal to rs2. It produces no register write-back.
- R5: The load immediate is instruction bits [31:20]. The store immediate is bits [31:25] above bits [11:7]. Both are sign-extended, and the request address is rs1 plus the immediate, modulo 2^64.
- R6: A load whose destination field (bits [11:7]) is 0 still issues its read but never raises wb_en_o.
- R7: For any other opcode/funct3 pair, not_mine_o is high in the same cycle as instr_valid_i. The instruction is not accepted and no request follows.
- R8: A request stays asserted with unchanged address, data, enable and size until req_ready_i is seen. instr_ready_o is low from acceptance until the operation ends.
- R9: wb_en_o rises in the cycle after the cycle in which rsp_valid_i is sampled. It lasts exactly one cycle, and wb_rd_o carries the load's destination.
- R10: While rst_ni is low and just after reset, req_valid_o and wb_en_o are low and instr_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word offered |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Base register value |
| rs2_val_i | input | XLEN | Store data register value |
| instr_ready_o | output | 1 | Unit idle, can accept |
| not_mine_o | output | 1 | Offered instruction is not handled here |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory accepts request |
| req_addr_o | output | XLEN | Byte address |
| req_we_o | output | 1 | Write request |
| req_size_o | output | 2 | log2 of access bytes |
| req_wdata_o | output | XLEN | Write data |
| req_be_o | output | XLEN/8 | Byte enables |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_rdata_i | input | XLEN | Read beat |
| wb_en_o | output | 1 | Register write strobe |
| wb_rd_o | output | 5 | Destination register |
| wb_data_o | output | XLEN | Write-back value |

## Verification
The bench uses the only meaningful width, XLEN = 64, which gives an 8-lane byte enable and places the word-half select at address bit 2. At this size it sweeps every funct3 value under both memory opcodes. It also walks aligned immediates across the signed 12-bit range, including both extremes, and wraps the address past 2^64. Request stalls of several lengths and destination 0 are included, so both halves and both extension cases are covered.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [2:0] F3_WORD_U = 3'b110;
  localparam logic [2:0] F3_DWORD  = 3'b011;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned IMM_W    = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  typedef struct packed {
    logic              hit;
    logic              store;
    logic              word;
    logic [REG_AW-1:0] rd;
  } dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [31:0]     instr_i,
  output dec_t            dec_o,
  output logic [XLEN-1:0] imm_o
);
  logic [6:0]       opc;
  logic [2:0]       f3;
  logic             is_ld_w, is_ld_d, is_st_d;
  logic [IMM_W-1:0] imm12;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];

  assign is_ld_w = (opc == OPC_LOAD)  && (f3 == F3_WORD_U);
  assign is_ld_d = (opc == OPC_LOAD)  && (f3 == F3_DWORD);
  assign is_st_d = (opc == OPC_STORE) && (f3 == F3_DWORD);

  always_comb begin
    dec_o.hit   = is_ld_w | is_ld_d | is_st_d;
    dec_o.store = is_st_d;
    dec_o.word  = is_ld_w;
    dec_o.rd    = is_st_d ? '0 : instr_i[11:7];
  end

  // store immediate is split across two fields
  assign imm12 = is_st_d ? {instr_i[31:25], instr_i[11:7]} : instr_i[31:20];
  assign imm_o = {{(XLEN-IMM_W){imm12[IMM_W-1]}}, imm12};
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned BE_W = XLEN / 8,
  localparam int unsigned SZ_D = $clog2(BE_W),
  localparam int unsigned HSEL = SZ_D - 1
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            word_i,
  output logic [XLEN-1:0] addr_o,
  output logic [BE_W-1:0] be_o,
  output logic [1:0]      size_o
);
  localparam int unsigned HALF = BE_W / 2;
  localparam logic [BE_W-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  assign addr_o = base_i + imm_i;

  always_comb begin
    if (word_i) begin
      be_o   = addr_o[HSEL] ? ~LO_MASK : LO_MASK;
      size_o = 2'(SZ_D - 1);
    end else begin
      be_o   = '1;
      size_o = 2'(SZ_D);
    end
  end
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned HW = XLEN / 2
) (
  input  logic [XLEN-1:0] rdata_i,
  input  logic            word_i,
  input  logic            hi_sel_i,
  output logic [XLEN-1:0] data_o
);
  logic [HW-1:0] half;

  assign half   = hi_sel_i ? rdata_i[XLEN-1:HW] : rdata_i[HW-1:0];
  assign data_o = word_i ? {{HW{1'b0}}, half} : rdata_i;
endmodule

// File: rtl/dw_lsu.sv
module dw_lsu
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned BE_W = XLEN / 8,
  localparam int unsigned HSEL = $clog2(BE_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            instr_ready_o,
  output logic            not_mine_o,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic [XLEN-1:0] req_addr_o,
  output logic            req_we_o,
  output logic [1:0]      req_size_o,
  output logic [XLEN-1:0] req_wdata_o,
  output logic [BE_W-1:0] req_be_o,
  input  logic            rsp_valid_i,
  input  logic [XLEN-1:0] rsp_rdata_i,
  output logic            wb_en_o,
  output logic [4:0]      wb_rd_o,
  output logic [XLEN-1:0] wb_data_o
);
  dec_t            dec;
  logic [XLEN-1:0] imm, addr_d, ext_data;
  logic [BE_W-1:0] be_d;
  logic [1:0]      size_d;
  logic            take;

  state_e          state_q;
  logic [XLEN-1:0] addr_q, wdata_q, wb_data_q;
  logic [BE_W-1:0] be_q;
  logic [1:0]      size_q;
  logic            we_q, word_q, wb_en_q;
  logic [4:0]      rd_q;

  lsu_decode #(.XLEN(XLEN)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec),
    .imm_o   (imm)
  );

  lsu_agen #(.XLEN(XLEN)) u_agen (
    .base_i (rs1_val_i),
    .imm_i  (imm),
    .word_i (dec.word),
    .addr_o (addr_d),
    .be_o   (be_d),
    .size_o (size_d)
  );

  lsu_extend #(.XLEN(XLEN)) u_ext (
    .rdata_i  (rsp_rdata_i),
    .word_i   (word_q),
    .hi_sel_i (addr_q[HSEL]),
    .data_o   (ext_data)
  );

  assign instr_ready_o = (state_q == ST_IDLE);
  assign not_mine_o    = instr_valid_i && !dec.hit;
  assign take          = instr_valid_i && instr_ready_o && dec.hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_REQ;
          addr_q  <= addr_d;
          wdata_q <= rs2_val_i;
          be_q    <= be_d;
          size_q  <= size_d;
          we_q    <= dec.store;
          word_q  <= dec.word;
          rd_q    <= dec.rd;
        end
        ST_REQ: if (req_ready_i) state_q <= we_q ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // write-back register: one-cycle strobe, never for x0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_q   <= 1'b0;
      wb_data_q <= '0;
    end else begin
      wb_en_q <= 1'b0;
      if (state_q == ST_WAIT && rsp_valid_i) begin
        wb_en_q   <= (rd_q != '0);
        wb_data_q <= ext_data;
      end
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_addr_o  = addr_q;
  assign req_we_o    = we_q;
  assign req_size_o  = size_q;
  assign req_wdata_o = wdata_q;
  assign req_be_o    = be_q;
  assign wb_en_o     = wb_en_q;
  assign wb_rd_o     = rd_q;
  assign wb_data_o   = wb_data_q;
endmodule

// File: rtl/dw_lsu_checker.sv
module dw_lsu_checker #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned BE_W = XLEN / 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_ready_o,
  input logic            not_mine_o,
  input logic            req_valid_o,
  input logic            req_ready_i,
  input logic [XLEN-1:0] req_addr_o,
  input logic            req_we_o,
  input logic [1:0]      req_size_o,
  input logic [XLEN-1:0] req_wdata_o,
  input logic [BE_W-1:0] req_be_o,
  input logic            wb_en_o,
  input logic [4:0]      wb_rd_o
);
  p_word_be_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_size_o == 2'd2 |-> $countones(req_be_o) == BE_W/2 &&
      (req_be_o[0] != req_be_o[BE_W-1]));

  p_dword_be_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_size_o == 2'd3 |-> $countones(req_be_o) == BE_W);

  p_store_dword_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_we_o |-> req_size_o == 2'd3);

  p_no_x0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_rd_o != 5'd0);

  p_foreign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_mine_o && instr_ready_o |=> !req_valid_o);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
      $stable(req_wdata_o) && $stable(req_be_o) && $stable(req_size_o));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !instr_ready_o);

  p_wb_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> !wb_en_o);
endmodule

bind dw_lsu dw_lsu_checker #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_ready_o (instr_ready_o),
  .not_mine_o    (not_mine_o),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_addr_o    (req_addr_o),
  .req_we_o      (req_we_o),
  .req_size_o    (req_size_o),
  .req_wdata_o   (req_wdata_o),
  .req_be_o      (req_be_o),
  .wb_en_o       (wb_en_o),
  .wb_rd_o       (wb_rd_o)
);

// File: tb/sim_dw_lsu.sv
module sim_dw_lsu;
  localparam int unsigned XLEN = 64;
  localparam int unsigned CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [63:0]     rs1 = '0, rs2 = '0;
  logic            instr_ready, not_mine, req_valid, req_we, wb_en;
  logic            req_ready = 1'b0, rsp_valid = 1'b0;
  logic [63:0]     req_addr, req_wdata, wb_data;
  logic [63:0]     rsp_rdata = '0;
  logic [1:0]      req_size;
  logic [7:0]      req_be;
  logic [4:0]      wb_rd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dw_lsu #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .rs1_val_i(rs1), .rs2_val_i(rs2), .instr_ready_o(instr_ready),
    .not_mine_o(not_mine), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_addr_o(req_addr), .req_we_o(req_we), .req_size_o(req_size),
    .req_wdata_o(req_wdata), .req_be_o(req_be), .rsp_valid_i(rsp_valid),
    .rsp_rdata_i(rsp_rdata), .wb_en_o(wb_en), .wb_rd_o(wb_rd), .wb_data_o(wb_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx12(input logic [11:0] v);
    return {{52{v[11]}}, v};
  endfunction

  task automatic do_load(input logic [2:0] f3, input logic [4:0] rd,
                         input logic [63:0] base, input logic [11:0] imm,
                         input logic [63:0] beat, input int stall);
    logic [63:0] ea, exp_d;
    logic [7:0]  exp_be;
    bit          word;
    word  = (f3 == 3'b110);
    ea    = base + sx12(imm);
    exp_be = word ? (ea[2] ? 8'hF0 : 8'h0F) : 8'hFF;
    exp_d  = word ? {32'h0, (ea[2] ? beat[63:32] : beat[31:0])} : beat;
    @(negedge clk);
    instr = {imm, 5'd1, f3, rd, 7'b0000011};
    rs1 = base; instr_valid = 1'b1;
    #1 chk(!not_mine && instr_ready, "R7 own load", {62'h0, not_mine, instr_ready}, 64'h1);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(req_valid && !req_we, "R1/R3 read issued", {62'h0, req_valid, req_we}, 64'h2);
    chk(req_addr == ea, "R5 address", req_addr, ea);
    chk(req_be == exp_be, word ? "R1 word be" : "R3 dword be", {56'h0, req_be}, {56'h0, exp_be});
    chk(req_size == (word ? 2'd2 : 2'd3), word ? "R1 size" : "R3 size",
        {62'h0, req_size}, word ? 64'd2 : 64'd3);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(req_valid && req_addr == ea && req_be == exp_be && !instr_ready,
          "R8 request held", req_addr, ea);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(!req_valid && !wb_en, "R8 request dropped after accept", {62'h0, req_valid, wb_en}, 64'h0);
    rsp_valid = 1'b1; rsp_rdata = beat;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_rdata = ~beat;
    if (rd != 0) begin
      chk(wb_en && wb_rd == rd, "R9 writeback strobe", {58'h0, wb_en, wb_rd}, {58'h0, 1'b1, rd});
      chk(wb_data == exp_d, word ? "R2 zero-extended half" : "R3 full beat", wb_data, exp_d);
    end else begin
      chk(!wb_en, "R6 no write to x0", {63'h0, wb_en}, 64'h0);
    end
    @(negedge clk);
    chk(!wb_en && instr_ready, "R9 single-cycle strobe", {62'h0, wb_en, instr_ready}, 64'h1);
  endtask

  task automatic do_store(input logic [63:0] base, input logic [11:0] imm,
                          input logic [63:0] data, input int stall);
    logic [63:0] ea;
    ea = base + sx12(imm);
    @(negedge clk);
    instr = {imm[11:5], 5'd2, 5'd1, 3'b011, imm[4:0], 7'b0100011};
    rs1 = base; rs2 = data; instr_valid = 1'b1;
    #1 chk(!not_mine, "R7 own store", {63'h0, not_mine}, 64'h0);
    @(negedge clk);
    instr_valid = 1'b0; rs2 = ~data;
    chk(req_valid && req_we && req_size == 2'd3 && req_be == 8'hFF, "R4 store request",
        {52'h0, req_valid, req_we, req_size, req_be}, {52'h0, 1'b1, 1'b1, 2'd3, 8'hFF});
    chk(req_addr == ea, "R5 store address", req_addr, ea);
    chk(req_wdata == data, "R4 store data", req_wdata, data);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(req_valid && req_wdata == data && req_addr == ea, "R8 store held", req_wdata, data);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(!req_valid && !wb_en && instr_ready, "R4 store completes without writeback",
        {61'h0, req_valid, wb_en, instr_ready}, 64'h1);
    @(negedge clk);
    chk(!wb_en, "R4 no writeback later", {63'h0, wb_en}, 64'h0);
  endtask

  task automatic do_foreign(input logic [31:0] w);
    @(negedge clk);
    instr = w; instr_valid = 1'b1;
    #1 chk(not_mine, "R7 foreign flagged", {63'h0, not_mine}, 64'h1);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(!req_valid && instr_ready && !wb_en, "R7 foreign ignored",
        {61'h0, req_valid, instr_ready, wb_en}, 64'h2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    chk(!req_valid && !wb_en && instr_ready, "R10 in reset", {61'h0, req_valid, wb_en, instr_ready}, 64'h1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !wb_en && instr_ready, "R10 after reset", {61'h0, req_valid, wb_en, instr_ready}, 64'h1);

    // funct3 sweep under both memory opcodes
    for (int f = 0; f < 8; f++) begin
      if (f == 6 || f == 3) do_load(3'(f), 5'd7, 64'h1000, 12'h010, 64'hF1E2_D3C4_8765_4321, 0);
      else do_foreign({12'h010, 5'd1, 3'(f), 5'd7, 7'b0000011});
      if (f == 3) do_store(64'h2000, 12'h018, 64'hDEAD_BEEF_0123_4567, 0);
      else do_foreign({7'h0, 5'd2, 5'd1, 3'(f), 5'd8, 7'b0100011});
    end
    do_foreign({12'h0, 5'd1, 3'b011, 5'd3, 7'b0010011});
    do_foreign({12'h0, 5'd1, 3'b110, 5'd3, 7'b0000111});

    // immediate sweep for word loads: both halves, signed range
    for (int k = -512; k < 512; k += 37) begin
      logic [11:0] im;
      im = 12'(k * 4);
      do_load(3'b110, 5'(k & 31), 64'h0000_0000_0001_0000, im,
              {32'h8000_0000 | 32'(k), 32'hFFFF_0000 ^ 32'(k)}, k & 3);
    end
    // doubleword loads and stores over the range
    for (int k = -256; k < 256; k += 29) begin
      logic [11:0] im;
      im = 12'(k * 8);
      do_load(3'b011, 5'd31, 64'h4000 + 64'(k * 64), im, {32'(k), 32'h5A5A_A5A5}, (k >> 2) & 3);
      do_store(64'h8000 - 64'(k * 16), im, {32'hC0DE_0000 ^ 32'(k), 32'(k)}, k & 3);
    end
    // extremes, wrap-around and x0 destination
    do_load(3'b011, 5'd1, 64'h0, 12'h800, 64'h0123_4567_89AB_CDEF, 1);
    do_load(3'b110, 5'd2, 64'hFFFF_FFFF_FFFF_FFF8, 12'h00C, 64'hFFFF_FFFF_7FFF_FFFF, 2);
    do_store(64'hFFFF_FFFF_FFFF_FFF0, 12'h7F8, 64'hFFFF_FFFF_FFFF_FFFF, 3);
    do_store(64'h10, 12'h800, 64'h1, 0);
    do_load(3'b110, 5'd0, 64'h3000, 12'h004, 64'hAAAA_BBBB_CCCC_DDDD, 1);
    do_load(3'b011, 5'd0, 64'h3000, 12'hFF8, 64'h1111_2222_3333_4444, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule